// File: doc/BRIEF.md
# Interleaved Parallel Telecom Bus Port

This block connects the per-link byte streams of a 28-link framer to a 17-bit parallel system bus. Three such ports share the bus byte by byte, so together they carry a full STS-3/STM-1 rate. Each bus word holds an 8-bit signaling/control field, a parity bit and a data byte. The transmit and receive directions each have their own clock and frame sync. Each direction counts byte slots from its frame sync and claims one slot in every group of three. The slot it claims is chosen by a configured phase.

On the transmit side the port asks the framer for a byte one cycle ahead of an owned slot. It then drives the registered word with an output enable that is high only during that slot. An external tri-state driver keys off that enable. On the receive side the port captures owned slots and ignores all other slots. It also checks parity and reports mismatches as a strobe and a saturating count. Parity sense is selectable. An optional mode changes how the link-0 byte of alternate (frame-alignment) frames is treated.

Top module: `tbus_port`

## Requirements
- R1: While reset is applied and right after it, tx_oe_o, tx_bus_o, rx_valid_o, rx_perr_o and rx_err_cnt_o are all zero.
- R2: Until the first frame sync of a direction after reset, that direction owns no slot: tx_req_o and tx_oe_o stay low, and rx_valid_o stays low.
- R3: If tx_fs_i is high in cycle c, slot 0 is on the bus in cycle c+1, and the slot number then rises by one each cycle. Slot s is owned when s mod 3 equals cfg_phase. tx_req_o is high in the cycle before an owned slot, and tx_oe_o is high exactly during owned slots.
- R4: A bus word is laid out as bits [16:9] signaling, bit [8] parity and bits [7:0] data. In a cycle that is not owned, tx_oe_o is 0 and tx_bus_o is all zero.
- R5: Bit 8 makes the number of ones in bits [8:0] even when cfg_odd_par is 0, and odd when it is 1.
- R6: With cfg_phase equal to 3, no slot is owned in either direction.
- R7: tx_link_o and rx_link_o give the number of owned slots since the frame sync, wrapping at 28; the first owned slot is link 0. The transmitted word carries the tx_data_i and tx_sig_i presented in the request cycle.
- R8: rx_fs_i is high in the cycle that carries slot 0 on rx_bus_i. One cycle after an owned slot, rx_valid_o is high with that slot's data, signaling and link. After a slot that is not owned, rx_valid_o is low and the captured fields are not updated.
- R9: A parity mismatch on a captured slot raises rx_perr_o for one cycle, together with rx_valid_o. Slots that are not captured never raise it.
- R10: rx_err_cnt_o goes up by one in the same cycle as each rx_perr_o strobe. It holds at all ones once it reaches that value and is cleared only by reset.
- R11: In each direction the first frame sync after reset starts an alignment frame, and frame types then alternate at each sync. tx_fas_o gives the type of the frame being requested. With cfg_dbl_nfas at 0, the link-0 byte of every frame passes through unchanged.
- R12: With cfg_dbl_nfas at 1, on transmit the link-0 slot of an alignment frame carries the link-0 data byte of the most recent non-alignment frame, or 0 if there has been none since reset. Its signaling still comes from tx_sig_i, and its parity is computed for the substituted byte.
- R13: With cfg_dbl_nfas at 1, on receive the link-0 slot of an alignment frame is neither delivered nor parity-checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit bus clock |
| rx_clk | input | 1 | Receive bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_phase | input | 2 | Owned slot within each group of three (3 = none) |
| cfg_odd_par | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_dbl_nfas | input | 1 | Enables double non-alignment link-0 handling |
| tx_fs_i | input | 1 | Transmit frame sync; slot 0 follows one cycle later |
| tx_req_o | output | 1 | Framer byte request for the next slot |
| tx_link_o | output | 5 | Link index of the requested byte |
| tx_fas_o | output | 1 | Requested byte belongs to an alignment frame |
| tx_data_i | input | 8 | Framer data byte for the request |
| tx_sig_i | input | 8 | Framer signaling byte for the request |
| tx_bus_o | output | 17 | Transmit bus word |
| tx_oe_o | output | 1 | Bus drive enable, high only in owned slots |
| rx_fs_i | input | 1 | Receive frame sync, coincident with slot 0 |
| rx_bus_i | input | 17 | Receive bus word |
| rx_valid_o | output | 1 | Captured byte is valid |
| rx_link_o | output | 5 | Link index of the captured byte |
| rx_data_o | output | 8 | Captured data byte |
| rx_sig_o | output | 8 | Captured signaling byte |
| rx_perr_o | output | 1 | One-cycle parity error strobe |
| rx_err_cnt_o | output | 8 | Saturating parity error count |

## Verification
The transmit word and its enable appear one cycle after the edge that samples the frame sync or request. The bench therefore raises tx_fs_i at a falling edge and reads slot i at the i-th falling edge after that. A received slot's valid flag, fields and error strobe are due one cycle after the slot is on the bus. The bench drives each word at a falling edge and checks it at the next falling edge, while it drives the following word. The error count moves in the same cycle as its strobe, so both are compared at that falling edge against a count the bench keeps itself.

// File: rtl/tbus_pkg.sv
package tbus_pkg;

  localparam int WORD_W = 17;

  typedef struct packed {
    logic [7:0] sig;
    logic       par;
    logic [7:0] data;
  } tbus_word_t;

  // parity bit that brings bits [8:0] to the chosen sense
  function automatic logic par_of(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

endpackage

// File: rtl/tbus_rst_sync.sv
module tbus_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_sn = sh_q[1];

endmodule

// File: rtl/tbus_slot_trk.sv
module tbus_slot_trk #(
  parameter int GRP    = 3,
  parameter int NLINK  = 28,
  parameter int LINK_W = 5,
  parameter int PH_W   = 2
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              fs_i,
  input  logic [PH_W-1:0]   phase_i,
  output logic              own_o,
  output logic [LINK_W-1:0] link_o,
  output logic              fas_o
);

  localparam int GW = (GRP > 1) ? $clog2(GRP) : 1;
  localparam logic [GW-1:0]     GRP_LAST  = GW'(GRP - 1);
  localparam logic [LINK_W-1:0] LINK_LAST = LINK_W'(NLINK - 1);

  logic [GW-1:0]     grp_q, grp_d;
  logic [LINK_W-1:0] cnt_q, cnt_d;
  logic              odd_q, odd_d;
  logic              sync_q, sync_d;

  // next-state: describes the slot about to be placed on / taken from the bus
  always_comb begin
    sync_d = sync_q | fs_i;
    odd_d  = fs_i ? ~odd_q : odd_q;
    if (fs_i || (grp_q == GRP_LAST)) grp_d = '0;
    else                             grp_d = grp_q + 1'b1;
    link_o = fs_i ? '0 : cnt_q;
    own_o  = rst_sn && sync_d && (int'(phase_i) == int'(grp_d));
    fas_o  = ~odd_d;
    cnt_d  = link_o;
    if (own_o) cnt_d = (link_o == LINK_LAST) ? '0 : link_o + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sync_q <= 1'b0;
      grp_q  <= '0;
      cnt_q  <= '0;
      odd_q  <= 1'b1;
    end else begin
      sync_q <= sync_d;
      grp_q  <= grp_d;
      cnt_q  <= cnt_d;
      odd_q  <= odd_d;
    end
  end

endmodule

// File: rtl/tbus_tx.sv
module tbus_tx
  import tbus_pkg::*;
#(
  parameter int LINK_W = 5
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              own_i,
  input  logic [LINK_W-1:0] link_i,
  input  logic              fas_i,
  input  logic              odd_par_i,
  input  logic              dbl_nfas_i,
  input  logic [7:0]        data_i,
  input  logic [7:0]        sig_i,
  output logic [WORD_W-1:0] bus_o,
  output logic              oe_o
);

  tbus_word_t word_q, word_d;
  logic       oe_q, oe_d;
  logic [7:0] hold_q;
  logic       hold_en;
  logic       lead;
  logic [7:0] dsel;

  always_comb begin
    lead    = own_i && (link_i == '0);
    hold_en = lead && !fas_i;
    dsel    = (lead && fas_i && dbl_nfas_i) ? hold_q : data_i;
    oe_d    = own_i;
    word_d  = '0;
    if (own_i) begin
      word_d.sig  = sig_i;
      word_d.data = dsel;
      word_d.par  = par_of(dsel, odd_par_i);
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      word_q <= '0;
      oe_q   <= 1'b0;
      hold_q <= '0;
    end else begin
      word_q <= word_d;
      oe_q   <= oe_d;
      if (hold_en) hold_q <= data_i;
    end
  end

  assign bus_o = word_q;
  assign oe_o  = oe_q;

endmodule

// File: rtl/tbus_rx.sv
module tbus_rx
  import tbus_pkg::*;
#(
  parameter int LINK_W = 5,
  parameter int ERR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              own_i,
  input  logic [LINK_W-1:0] link_i,
  input  logic              fas_i,
  input  logic              odd_par_i,
  input  logic              dbl_nfas_i,
  input  logic [WORD_W-1:0] bus_i,
  output logic              valid_o,
  output logic [LINK_W-1:0] link_o,
  output logic [7:0]        data_o,
  output logic [7:0]        sig_o,
  output logic              perr_o,
  output logic [ERR_W-1:0]  err_cnt_o
);

  tbus_word_t        w;
  logic              take, bad, cnt_en;
  logic              valid_q, perr_q;
  logic [LINK_W-1:0] link_q;
  logic [7:0]        data_q, sig_q;
  logic [ERR_W-1:0]  cnt_q;

  assign w = bus_i;

  always_comb begin
    take   = own_i && !(dbl_nfas_i && fas_i && (link_i == '0));
    bad    = take && (par_of(w.data, odd_par_i) != w.par);
    cnt_en = bad && (cnt_q != '1);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      valid_q <= 1'b0;
      perr_q  <= 1'b0;
      link_q  <= '0;
      data_q  <= '0;
      sig_q   <= '0;
      cnt_q   <= '0;
    end else begin
      valid_q <= take;
      perr_q  <= bad;
      if (take) begin
        link_q <= link_i;
        data_q <= w.data;
        sig_q  <= w.sig;
      end
      if (cnt_en) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign valid_o   = valid_q;
  assign perr_o    = perr_q;
  assign link_o    = link_q;
  assign data_o    = data_q;
  assign sig_o     = sig_q;
  assign err_cnt_o = cnt_q;

endmodule

// File: rtl/tbus_port.sv
module tbus_port
  import tbus_pkg::*;
#(
  parameter int GRP    = 3,
  parameter int NLINK  = 28,
  parameter int LINK_W = $clog2(NLINK),
  parameter int ERR_W  = 8,
  parameter int PH_W   = $clog2(GRP + 1)
) (
  input  logic              tx_clk,
  input  logic              rx_clk,
  input  logic              rst_n,
  input  logic [PH_W-1:0]   cfg_phase,
  input  logic              cfg_odd_par,
  input  logic              cfg_dbl_nfas,
  input  logic              tx_fs_i,
  output logic              tx_req_o,
  output logic [LINK_W-1:0] tx_link_o,
  output logic              tx_fas_o,
  input  logic [7:0]        tx_data_i,
  input  logic [7:0]        tx_sig_i,
  output logic [WORD_W-1:0] tx_bus_o,
  output logic              tx_oe_o,
  input  logic              rx_fs_i,
  input  logic [WORD_W-1:0] rx_bus_i,
  output logic              rx_valid_o,
  output logic [LINK_W-1:0] rx_link_o,
  output logic [7:0]        rx_data_o,
  output logic [7:0]        rx_sig_o,
  output logic              rx_perr_o,
  output logic [ERR_W-1:0]  rx_err_cnt_o
);

  localparam int NDIR = 2;  // index 0 = transmit, 1 = receive

  logic [NDIR-1:0]   clk_a, fs_a, rst_a, own_a, fas_a;
  logic [LINK_W-1:0] link_a [NDIR];

  assign clk_a = {rx_clk, tx_clk};
  assign fs_a  = {rx_fs_i, tx_fs_i};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    tbus_rst_sync u_rst (
      .clk    (clk_a[d]),
      .rst_n  (rst_n),
      .rst_sn (rst_a[d])
    );
    tbus_slot_trk #(
      .GRP(GRP), .NLINK(NLINK), .LINK_W(LINK_W), .PH_W(PH_W)
    ) u_trk (
      .clk     (clk_a[d]),
      .rst_sn  (rst_a[d]),
      .fs_i    (fs_a[d]),
      .phase_i (cfg_phase),
      .own_o   (own_a[d]),
      .link_o  (link_a[d]),
      .fas_o   (fas_a[d])
    );
  end

  assign tx_req_o  = own_a[0];
  assign tx_link_o = link_a[0];
  assign tx_fas_o  = fas_a[0];

  tbus_tx #(.LINK_W(LINK_W)) u_tx (
    .clk        (tx_clk),
    .rst_sn     (rst_a[0]),
    .own_i      (own_a[0]),
    .link_i     (link_a[0]),
    .fas_i      (fas_a[0]),
    .odd_par_i  (cfg_odd_par),
    .dbl_nfas_i (cfg_dbl_nfas),
    .data_i     (tx_data_i),
    .sig_i      (tx_sig_i),
    .bus_o      (tx_bus_o),
    .oe_o       (tx_oe_o)
  );

  tbus_rx #(.LINK_W(LINK_W), .ERR_W(ERR_W)) u_rx (
    .clk        (rx_clk),
    .rst_sn     (rst_a[1]),
    .own_i      (own_a[1]),
    .link_i     (link_a[1]),
    .fas_i      (fas_a[1]),
    .odd_par_i  (cfg_odd_par),
    .dbl_nfas_i (cfg_dbl_nfas),
    .bus_i      (rx_bus_i),
    .valid_o    (rx_valid_o),
    .link_o     (rx_link_o),
    .data_o     (rx_data_o),
    .sig_o      (rx_sig_o),
    .perr_o     (rx_perr_o),
    .err_cnt_o  (rx_err_cnt_o)
  );

endmodule

// File: rtl/tbus_port_chk.sv
module tbus_port_chk #(
  parameter int PH_W  = 2,
  parameter int ERR_W = 8
) (
  input logic             tx_clk,
  input logic             rx_clk,
  input logic             rst_n,
  input logic [PH_W-1:0]  cfg_phase,
  input logic             cfg_odd_par,
  input logic             tx_req_o,
  input logic [16:0]      tx_bus_o,
  input logic             tx_oe_o,
  input logic             rx_valid_o,
  input logic             rx_perr_o,
  input logic [ERR_W-1:0] rx_err_cnt_o
);

  // R3
  oe_follows_req_chk: assert property (@(posedge tx_clk) disable iff (!rst_n)
    tx_oe_o == $past(tx_req_o));

  // R5
  tx_parity_chk: assert property (@(posedge tx_clk) disable iff (!rst_n)
    (tx_oe_o && $stable(cfg_odd_par)) |-> ((^tx_bus_o[8:0]) == cfg_odd_par));

  // R6
  phase_none_chk: assert property (@(posedge tx_clk) disable iff (!rst_n)
    (cfg_phase == PH_W'(3) && $past(cfg_phase) == PH_W'(3)) |-> !tx_oe_o);

  // R9
  perr_with_valid_chk: assert property (@(posedge rx_clk) disable iff (!rst_n)
    rx_perr_o |-> rx_valid_o);

  // R10
  errcnt_step_chk: assert property (@(posedge rx_clk) disable iff (!rst_n)
    (rx_err_cnt_o != $past(rx_err_cnt_o)) |->
      (rx_perr_o && rx_err_cnt_o == $past(rx_err_cnt_o) + 1'b1));

  // R10
  errcnt_sat_chk: assert property (@(posedge rx_clk) disable iff (!rst_n)
    ($past(rx_err_cnt_o) == '1) |-> (rx_err_cnt_o == '1));

endmodule

bind tbus_port tbus_port_chk #(.PH_W(PH_W), .ERR_W(ERR_W)) u_chk (
  .tx_clk       (tx_clk),
  .rx_clk       (rx_clk),
  .rst_n        (rst_n),
  .cfg_phase    (cfg_phase),
  .cfg_odd_par  (cfg_odd_par),
  .tx_req_o     (tx_req_o),
  .tx_bus_o     (tx_bus_o),
  .tx_oe_o      (tx_oe_o),
  .rx_valid_o   (rx_valid_o),
  .rx_perr_o    (rx_perr_o),
  .rx_err_cnt_o (rx_err_cnt_o)
);

// File: tb/tb_tbus_port.sv
`timescale 1ns/1ps
module tb_tbus_port;

  localparam int NL = 28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_phase = 2'd0;
  logic        cfg_odd_par = 1'b0;
  logic        cfg_dbl_nfas = 1'b0;
  logic        tx_fs = 1'b0;
  logic        rx_fs = 1'b0;
  logic [16:0] rx_bus = '0;
  logic        tx_req, tx_fas, tx_oe;
  logic [4:0]  tx_link;
  logic [7:0]  tx_data, tx_sig;
  logic [16:0] tx_bus;
  logic        rx_valid, rx_perr;
  logic [4:0]  rx_link;
  logic [7:0]  rx_data, rx_sig, rx_cnt;

  int n_chk = 0;
  int n_fail = 0;
  int tx_fs_cnt = 0;
  int rx_fs_cnt = 0;
  int exp_cnt = 0;
  logic [7:0] b_hold = '0;

  always #2 clk = ~clk;  // 250 MHz

  // framer model: bytes derived from link and frame type
  assign tx_data = {tx_fas, 2'b00, tx_link} ^ 8'h5A;
  assign tx_sig  = {1'b1, 2'b00, tx_link};

  tbus_port dut (
    .tx_clk(clk), .rx_clk(clk), .rst_n(rst_n),
    .cfg_phase(cfg_phase), .cfg_odd_par(cfg_odd_par), .cfg_dbl_nfas(cfg_dbl_nfas),
    .tx_fs_i(tx_fs), .tx_req_o(tx_req), .tx_link_o(tx_link), .tx_fas_o(tx_fas),
    .tx_data_i(tx_data), .tx_sig_i(tx_sig), .tx_bus_o(tx_bus), .tx_oe_o(tx_oe),
    .rx_fs_i(rx_fs), .rx_bus_i(rx_bus), .rx_valid_o(rx_valid), .rx_link_o(rx_link),
    .rx_data_o(rx_data), .rx_sig_o(rx_sig), .rx_perr_o(rx_perr), .rx_err_cnt_o(rx_cnt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [16:0] idle_word();
    return {8'h00, cfg_odd_par, 8'h00};
  endfunction

  function automatic logic [16:0] rx_word(input int i, input bit bad);
    logic [7:0] d, s;
    d = 8'((i * 7 + 3) & 255);
    s = 8'((i + 64) & 255);
    return {s, (^d) ^ cfg_odd_par ^ bad, d};
  endfunction

  task automatic do_reset(input int ph, input bit odd, input bit dbl);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_phase = 2'(ph);
    cfg_odd_par = odd;
    cfg_dbl_nfas = dbl;
    tx_fs = 1'b0;
    rx_fs = 1'b0;
    rx_bus = idle_word();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    tx_fs_cnt = 0;
    rx_fs_cnt = 0;
    exp_cnt = 0;
    b_hold = '0;
  endtask

  // transmit one frame of nslots, checking every slot (R3 R4 R5 R7 R11 R12)
  task automatic tx_frame(input int ph, input int nslots);
    bit fas;
    @(negedge clk);
    tx_fs = 1'b1;
    tx_fs_cnt++;
    fas = (tx_fs_cnt % 2) == 1;
    @(negedge clk);
    tx_fs = 1'b0;
    for (int i = 0; i < nslots; i++) begin
      bit owned;
      logic [4:0] lk;
      logic [7:0] d, s;
      owned = (ph < 3) && ((i % 3) == ph);
      lk = 5'(((i / 3) % NL));
      chk("R3 oe", 32'(tx_oe), 32'(owned));
      if (owned) begin
        d = {fas, 2'b00, lk} ^ 8'h5A;
        s = {1'b1, 2'b00, lk};
        if (lk == 0 && !fas) b_hold = d;
        if (lk == 0 && fas && cfg_dbl_nfas) d = b_hold;
        chk("R4 R5 R7 R12 word", 32'(tx_bus), 32'({s, (^d) ^ cfg_odd_par, d}));
      end else begin
        chk("R4 idle", 32'(tx_bus), 32'h0);
      end
      @(negedge clk);
    end
  endtask

  // receive one frame; slots with i % bad_every == 0 carry bad parity (R8 R9 R10 R13)
  task automatic rx_frame(input int ph, input int nslots, input int bad_every);
    bit fas;
    rx_fs = 1'b1;
    rx_fs_cnt++;
    fas = (rx_fs_cnt % 2) == 1;
    rx_bus = rx_word(0, bad_every != 0);
    for (int i = 0; i < nslots; i++) begin
      bit owned, bad;
      logic [4:0] lk;
      logic [16:0] w;
      @(negedge clk);
      rx_fs = 1'b0;
      w = rx_word(i, (bad_every != 0) && (i % bad_every == 0));
      bad = (bad_every != 0) && (i % bad_every == 0);
      lk = 5'(((i / 3) % NL));
      owned = (ph < 3) && ((i % 3) == ph) && !(cfg_dbl_nfas && fas && lk == 0);
      chk("R8 valid", 32'(rx_valid), 32'(owned));
      if (owned) begin
        chk("R8 data", 32'(rx_data), 32'(w[7:0]));
        chk("R8 sig", 32'(rx_sig), 32'(w[16:9]));
        chk("R7 rx link", 32'(rx_link), 32'(lk));
        chk("R9 perr", 32'(rx_perr), 32'(bad));
        if (bad && exp_cnt < 255) exp_cnt++;
      end else begin
        chk("R9 R13 no perr", 32'(rx_perr), 32'h0);
      end
      chk("R10 count", 32'(rx_cnt), 32'(exp_cnt));
      if (i + 1 < nslots) rx_bus = rx_word(i + 1, (bad_every != 0) && ((i + 1) % bad_every == 0));
      else                rx_bus = idle_word();
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 oe in reset", 32'(tx_oe), 32'h0);
    chk("R1 bus in reset", 32'(tx_bus), 32'h0);
    do_reset(0, 0, 0);
    chk("R1 oe", 32'(tx_oe), 32'h0);
    chk("R1 valid", 32'(rx_valid), 32'h0);
    chk("R1 perr", 32'(rx_perr), 32'h0);
    chk("R1 count", 32'(rx_cnt), 32'h0);
  endtask

  task automatic t_no_sync;
    int hits = 0;
    do_reset(0, 0, 0);
    for (int i = 0; i < 12; i++) begin
      rx_bus = rx_word(i, 0);
      @(negedge clk);
      if (tx_req || tx_oe || rx_valid) hits++;
    end
    chk("R2 no slots before sync", 32'(hits), 32'h0);
  endtask

  task automatic t_tx_phases;
    for (int p = 0; p < 3; p++) begin
      do_reset(p, 0, 0);
      tx_frame(p, 12);
    end
  endtask

  task automatic t_tx_odd;
    do_reset(1, 1, 0);
    tx_frame(1, 9);
    tx_frame(1, 9);
  endtask

  task automatic t_phase_none;
    do_reset(3, 0, 0);
    tx_frame(3, 9);
    rx_frame(3, 9, 0);
  endtask

  task automatic t_link_wrap;
    do_reset(2, 0, 0);
    tx_frame(2, 3 * NL + 6);
  endtask

  task automatic t_rx_capture;
    do_reset(1, 0, 0);
    rx_frame(1, 12, 0);
    rx_frame(1, 9, 0);
  endtask

  task automatic t_rx_parity;
    do_reset(0, 0, 0);
    rx_frame(0, 12, 2);
    do_reset(0, 1, 0);
    rx_frame(0, 900, 1);
    chk("R10 saturated", 32'(rx_cnt), 32'd255);
  endtask

  task automatic t_dbl_tx;
    do_reset(0, 0, 0);
    tx_frame(0, 6);  // R11 alignment frame passes link 0 unchanged
    do_reset(0, 0, 1);
    tx_frame(0, 6);  // R12 alignment frame, no hold yet -> 0
    tx_frame(0, 6);
    tx_frame(0, 6);  // R12 substituted byte
  endtask

  task automatic t_dbl_rx;
    do_reset(0, 0, 0);
    rx_frame(0, 6, 3);  // R11 link 0 delivered and checked
    do_reset(0, 0, 1);
    rx_frame(0, 6, 3);  // R13 link 0 skipped despite bad parity
    rx_frame(0, 6, 3);
  endtask

  initial begin
    t_reset();
    t_no_sync();
    t_tx_phases();
    t_tx_odd();
    t_phase_none();
    t_link_wrap();
    t_rx_capture();
    t_rx_parity();
    t_dbl_tx();
    t_dbl_rx();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule